// File: doc/BRIEF.md
# Dual-Bank Display Data Memory Target

This block is a two-wire serial bus target. It sits in front of 512 bytes of internal storage, organised as two banks of 256 bytes. The target answers on the display-data-channel address pair. Address byte 0xA0 opens a memory write and 0xA1 opens a memory read. A static bank-select input chooses which physical bank is seen as segment zero. Every bus access goes to that segment through an 8-bit word offset.

The bus lines are sampled by the system clock through two-flop synchronisers. START, STOP and the SCL edges are found on the synchronised copies. Bits are shifted MSB first. The only output is an active-high pull-down enable for SDA. The target asserts it for its acknowledges and for the zero bits of read data. A random read is built from these steps:

1. A write-address byte.
2. An offset byte.
3. A repeated START.
4. The read-address byte.

A sequential read continues for as long as the host acknowledges each byte. The offset steps by one after every byte and wraps inside the 256-byte segment.

Top module: `ddc_bank_target`

## Requirements
- R1: After reset the SDA pull-down enable is low and the target is idle.
- R2: Before the first START, bus activity is ignored: a full 0xA0 byte clocked without a START is not acknowledged. While idle the pull-down is never asserted.
- R3: After a START, an address byte of 0xA0 or 0xA1 is acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge. Every further byte up to the next START is then ignored (no acknowledge).
- R4: In a write, the byte after 0xA0 loads the word offset. Each following byte is stored at the current offset, and the offset then increments. Every byte is acknowledged.
- R5: The offset increments by one after each byte written or read and wraps from 0xFF to 0x00, for both writes and reads.
- R6: A random read (0xA0, offset, repeated START without STOP, 0xA1) returns the byte stored at that offset, MSB first, with the pull-down asserted for every 0 bit.
- R7: In a read, a host ACK (SDA low in the ninth clock) makes the target send the next byte. A host NACK makes it release SDA and drive nothing more until a STOP or START.
- R8: With bank-select 0, segment zero is physical bytes 0..255. With bank-select 1, it is bytes 256..511. The physical byte is {bank-select, offset}, and the two banks hold independent data.
- R9: The pull-down enable changes only while the synchronised SCL is low.
- R10: A STOP (SDA rising while SCL high) returns the target to idle, so bytes clocked after a STOP without a new START are not acknowledged. START and STOP are never detected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| bank_sel_i | input | 1 | Maps segment zero to the lower (0) or upper (1) bank |
| sda_pull_o | output | 1 | Active-high SDA pull-down enable |

## Verification
Every reaction of the target is due three clock cycles after the bus edge that causes it. That delay is two synchroniser flops plus the register that holds the pull-down. So an acknowledge or a read bit appears three cycles after the SCL fall that opens its low phase. Stored data takes effect at the SCL fall that closes the eighth bit.

The bench moves SCL and host data only in six-cycle quarter steps. It reads SDA in the middle of each SCL-high phase, by which point any response is settled. The sweeps write and read back 32 bytes in each bank across the 0xFF-to-0x00 wrap.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFF_W  = 8;
  localparam int unsigned PHYS_W = OFF_W + 1;
  localparam logic [BYTE_W-1:0] DEV_WR = 8'hA0;
  localparam logic [BYTE_W-1:0] DEV_RD = 8'hA1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_OFFS, ST_WDATA, ST_RDATA, ST_WAIT_STOP
  } ddc_state_t;

  function automatic logic [OFF_W-1:0] offset_step(input logic [OFF_W-1:0] o);
    return o + 1'b1;
  endfunction

  function automatic logic [PHYS_W-1:0] bank_addr(input logic b, input logic [OFF_W-1:0] o);
    return {b, o};
  endfunction
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin scl_p[0] <= 1'b1; sda_p[0] <= 1'b1; end
          else        begin scl_p[0] <= scl_i; sda_p[0] <= sda_i; end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin scl_p[g] <= 1'b1; sda_p[g] <= 1'b1; end
          else        begin scl_p[g] <= scl_p[g-1]; sda_p[g] <= sda_p[g-1]; end
      end
    end
  endgenerate

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
    else        begin scl_d <= scl_s; sda_d <= sda_s; end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

  // R10: the two bus conditions are never seen together
  assert_start_stop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt));
endmodule

// File: rtl/ddc_store.sv
module ddc_store
  import ddc_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [PHYS_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [PHYS_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << PHYS_W;
  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk)
    if (we) cells[waddr] <= wdata;

  assign rdata = cells[raddr];
endmodule

// File: rtl/ddc_ctrl.sv
module ddc_ctrl
  import ddc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              bank_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              we,
  output logic [PHYS_W-1:0] waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic [PHYS_W-1:0] raddr,
  output logic              sda_pull
);
  localparam logic [3:0] CNT_BYTE = 4'(BYTE_W);
  localparam logic [3:0] CNT_ACK  = 4'(BYTE_W + 1);

  ddc_state_t        state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic [OFF_W-1:0]  offset_q;
  logic              pull_q, mack_q;

  // named internal events
  logic byte_done, slot_end;
  assign byte_done = scl_fall && (cnt_q == CNT_BYTE) && (state_q != ST_IDLE);
  assign slot_end  = scl_fall && (cnt_q == CNT_ACK)  && (state_q != ST_IDLE);

  assign we    = byte_done && (state_q == ST_WDATA);
  assign waddr = bank_addr(bank_sel, offset_q);
  assign wdata = sh_q;
  assign raddr = bank_addr(bank_sel, offset_q);
  assign sda_pull = pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      offset_q <= '0;
      pull_q   <= 1'b0;
      mack_q   <= 1'b0;
    end else if (start_evt) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
    end else if (stop_evt) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < CNT_BYTE) sh_q <= {sh_q[BYTE_W-2:0], sda_s};
        if (cnt_q == CNT_BYTE) mack_q <= ~sda_s;
        if (cnt_q < CNT_ACK) cnt_q <= cnt_q + 4'd1;
      end else if (byte_done) begin
        unique case (state_q)
          ST_ADDR: begin
            if (sh_q == DEV_WR)      begin state_q <= ST_OFFS;  pull_q <= 1'b1; end
            else if (sh_q == DEV_RD) begin state_q <= ST_RDATA; pull_q <= 1'b1; end
            else                     state_q <= ST_IDLE;
          end
          ST_OFFS: begin
            offset_q <= sh_q;
            state_q  <= ST_WDATA;
            pull_q   <= 1'b1;
          end
          ST_WDATA: begin
            offset_q <= offset_step(offset_q);
            pull_q   <= 1'b1;
          end
          ST_RDATA: begin
            offset_q <= offset_step(offset_q);
            pull_q   <= 1'b0;
          end
          default: pull_q <= 1'b0;
        endcase
      end else if (slot_end) begin
        cnt_q  <= '0;
        pull_q <= 1'b0;
        if (state_q == ST_RDATA) begin
          if (mack_q) begin
            tx_q   <= rd_data;
            pull_q <= ~rd_data[BYTE_W-1];
          end else begin
            state_q <= ST_WAIT_STOP;
          end
        end
      end else if (scl_fall && state_q == ST_RDATA && cnt_q != 4'd0) begin
        pull_q <= ~tx_q[3'd7 - cnt_q[2:0]];
      end
    end
  end

  // R9: pull-down moves only while SCL is low
  assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_s);
  // R2: an idle target never drives the line
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pull_q);
  // R7: after a host NACK the line stays released
  assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_STOP) |-> !pull_q);
  // R5: each stored byte advances the offset by one with wrap
  assert_offset_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> offset_q == offset_step($past(offset_q)));
endmodule

// File: rtl/ddc_bank_target.sv
module ddc_bank_target
  import ddc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic bank_sel_i,
  output logic sda_pull_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              we;
  logic [PHYS_W-1:0] waddr, raddr;
  logic [BYTE_W-1:0] wdata, rdata;

  ddc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  ddc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .bank_sel(bank_sel_i), .rd_data(rdata),
    .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr),
    .sda_pull(sda_pull_o)
  );

  ddc_store u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/sim_ddc_bank_target.sv
`timescale 1ns/1ps
module sim_ddc_bank_target;
  localparam int Q = 6;
  localparam int NB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic bank_sel = 1'b0;
  logic sda_pull;
  logic sda_line;
  logic sampled;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  ddc_bank_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .bank_sel_i(bank_sel), .sda_pull_o(sda_pull)
  );

  function automatic logic [7:0] pat(input int bank, input int i);
    if (bank == 0) return 8'((i * 37 + 5) & 255);
    else           return 8'(((i * 91 + 108) & 255) ^ 90);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b);
    tick(Q); m_sda = b; tick(Q); scl = 1'b1; tick(Q);
    sampled = sda_line; tick(Q); scl = 1'b0;
  endtask

  task automatic start_c();
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic stop_c();
    tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_x(b[i]);
    bit_x(1'b1);
    ack = ~sampled;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1);
      d = {d[6:0], sampled};
    end
    bit_x(~host_ack);
  endtask

  task automatic write_bank(input int bank);
    logic a;
    bank_sel = 1'(bank);
    start_c();
    send_byte(8'hA0, a); check("R3 write address ack", a, 1);
    send_byte(8'hF0, a); check("R4 offset ack", a, 1);
    for (int i = 0; i < NB; i++) begin
      send_byte(pat(bank, i), a); check("R4 data ack", a, 1);
    end
    stop_c();
  endtask

  task automatic read_bank(input int bank);
    logic a;
    logic [7:0] d;
    bank_sel = 1'(bank);
    start_c();
    send_byte(8'hA0, a); check("R6 write address ack", a, 1);
    send_byte(8'hF0, a); check("R6 offset ack", a, 1);
    start_c();
    send_byte(8'hA1, a); check("R3 read address ack", a, 1);
    for (int i = 0; i < NB; i++) begin
      recv_byte(i != NB - 1, d);
      check(bank == 0 ? "R6 R5 R8 bank0 read" : "R6 R5 R8 bank1 read", d, pat(bank, i));
    end
    recv_byte(1'b0, d); check("R7 released after NACK", d, 8'hFF);
    stop_c();
  endtask

  initial begin
    logic a;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    check("R1 reset pull", sda_pull, 0);
    scl = 1'b0; tick(Q);
    send_byte(8'hA0, a); check("R2 no ack before START", a, 0);
    start_c();
    send_byte(8'hA2, a); check("R3 foreign address nack", a, 0);
    send_byte(8'h00, a); check("R3 ignored after foreign address", a, 0);
    stop_c();
    scl = 1'b0;
    write_bank(0);
    scl = 1'b0;
    write_bank(1);
    scl = 1'b0;
    send_byte(8'hA0, a); check("R10 no ack after STOP", a, 0);
    scl = 1'b1; tick(Q);
    scl = 1'b0;
    read_bank(0);
    scl = 1'b0;
    read_bank(1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule